// File: doc/BRIEF.md
# Serial Driver Load Sequencer

This block sits on the host side of a chain of serial-input, latched output drivers. It takes one parallel word per transfer through a valid/ready handshake. It sends the word out bit by bit on a serial data line, with a shift clock that it generates itself. It then raises a strobe pulse so that the drivers copy their shift stages into their output latches. Each driver in the chain takes ten bits, so the word is ten bits wide for each cascaded device.

All waveform timing counts in cycles of the system clock. Each minimum is given in nanoseconds as a parameter, together with the system clock period. From these the block derives, rounding up, how long data is held before and after each shift edge, how long the shift clock stays high and low, how long it waits between the last shift edge and the strobe, and how long the strobe is high.

A latch-bypass input supports boards whose strobe line is tied active. While this input is high, the strobe output stays high and the blanking output stays high for as long as bits are being shifted. The outputs therefore never show partial data. When the input is low, blanking stays low.

Top module: `serdrv_load_seq`

## Requirements
- R1: After reset, with `bypass` low, `in_ready` is 1 and `ser_clk`, `ser_strobe`, `ser_blank` and `done` are all 0.
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle up to and including the `done` cycle. `in_valid` and `in_data` presented while `in_ready` is 0 have no effect on the word that is sent.
- R3: Each transfer gives exactly `10*DEVICES` rising edges on `ser_clk`, most significant bit first. A shift chain that moves in `ser_data` on every rising edge therefore holds the accepted word at the end, with bit W-1 in the stage furthest from the input.
- R4: `ser_data` is stable for at least LOW_C = max(ceil(SETUP_NS/P), ceil(SCK_LOW_NS/P)) cycles before each rising edge of `ser_clk`, where P is `SYS_CLK_NS`.
- R5: Each high phase of `ser_clk` lasts exactly HIGH_C = max(ceil(SCK_HIGH_NS/P), ceil(HOLD_NS/P)) cycles, and `ser_data` does not change during it.
- R6: With `bypass` low, `ser_strobe` rises exactly HIGH_C + GAP_C cycles after the last rising edge of `ser_clk`, where GAP_C = ceil(GAP_NS/P). This delay is at least GAP_NS.
- R7: With `bypass` low, `ser_strobe` stays high for exactly STB_C = ceil(STB_NS/P) cycles, and `ser_clk` is low while it is high.
- R8: `done` is high for exactly one cycle. That cycle comes W*(LOW_C+HIGH_C) + GAP_C + STB_C cycles after the accepting edge. `in_ready` returns to 1 in the following cycle.
- R9: While `bypass` is 1, `ser_strobe` is 1. `ser_blank` is 1 during every low and high phase of shifting and 0 at `done`. While `bypass` is 0, `ser_blank` is 0.
- R10: Each cycle count is the nanosecond minimum divided by the clock period, rounded up, with a floor of one cycle. The counts follow any clock period parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Latch-bypass mode: strobe held high, outputs blanked while shifting |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 10*DEVICES | Word to load |
| ser_data | output | 1 | Serial data to the first driver |
| ser_clk | output | 1 | Generated shift clock |
| ser_strobe | output | 1 | Latch strobe |
| ser_blank | output | 1 | Output blanking |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
`in_ready` falls in the cycle after the accepting edge. Each bit then takes LOW_C cycles low and HIGH_C cycles high. The strobe rises HIGH_C+GAP_C cycles after the last rising shift edge, and `done` comes W*(LOW_C+HIGH_C)+GAP_C+STB_C cycles after acceptance. The bench samples on falling clock edges and counts rising edges from the accepting edge onward. It measures each phase as a run of samples, and compares the runs with counts that its own functions derive from the nanosecond parameters. Two instances with different clock periods and chain lengths run the same checks, and the shifted chain is compared with the word when `done` appears.

// File: rtl/serdrv_load_pkg.sv
package serdrv_load_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_STB,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic sck;
        logic stb_pulse;
        logic shifting;
        logic ready;
        logic done;
    } seq_out_t;

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/serdrv_phase_timer.sv
module serdrv_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == CW'(1));
endmodule

// File: rtl/serdrv_shifter.sv
module serdrv_shifter #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         sdo,
    output logic         last_bit
);
    localparam int unsigned BCW = $clog2(W + 1);

    logic [W-1:0]   sreg;
    logic [BCW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= load_word;
            left <= BCW'(W);
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign sdo      = sreg[W-1];
    assign last_bit = (left == BCW'(1));
endmodule

// File: rtl/serdrv_ctrl.sv
module serdrv_ctrl
    import serdrv_load_pkg::*;
#(
    parameter int unsigned CW     = 4,
    parameter int unsigned LOW_C  = 1,
    parameter int unsigned HIGH_C = 1,
    parameter int unsigned GAP_C  = 1,
    parameter int unsigned STB_C  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          expire,
    input  logic          last_bit,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          sh_load,
    output logic          sh_shift,
    output seq_out_t      outs
);
    seq_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: if (in_valid) begin
                nxt      = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = CW'(LOW_C);
                sh_load  = 1'b1;
            end
            ST_LOW: if (expire) begin
                nxt      = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = CW'(HIGH_C);
            end
            ST_HIGH: if (expire) begin
                tmr_load = 1'b1;
                if (last_bit) begin
                    nxt     = ST_GAP;
                    tmr_val = CW'(GAP_C);
                end else begin
                    nxt      = ST_LOW;
                    tmr_val  = CW'(LOW_C);
                    sh_shift = 1'b1;
                end
            end
            ST_GAP: if (expire) begin
                nxt      = ST_STB;
                tmr_load = 1'b1;
                tmr_val  = CW'(STB_C);
            end
            ST_STB: if (expire) nxt = ST_FIN;
            ST_FIN: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        outs.sck       = (state == ST_HIGH);
        outs.stb_pulse = (state == ST_STB);
        outs.shifting  = (state == ST_LOW) || (state == ST_HIGH);
        outs.ready     = (state == ST_IDLE);
        outs.done      = (state == ST_FIN);
    end
endmodule

// File: rtl/serdrv_load_seq.sv
module serdrv_load_seq
    import serdrv_load_pkg::*;
#(
    parameter int unsigned DEVICES     = 2,
    parameter int unsigned BITS_PER_DEV = 10,
    parameter int unsigned SYS_CLK_NS  = 10,
    parameter int unsigned SETUP_NS    = 25,
    parameter int unsigned HOLD_NS     = 25,
    parameter int unsigned SCK_HIGH_NS = 50,
    parameter int unsigned SCK_LOW_NS  = 50,
    parameter int unsigned GAP_NS      = 100,
    parameter int unsigned STB_NS      = 50,
    localparam int unsigned W          = DEVICES * BITS_PER_DEV
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bypass,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         ser_data,
    output logic         ser_clk,
    output logic         ser_strobe,
    output logic         ser_blank,
    output logic         done
);
    localparam int unsigned LOW_C  = max_u(ns_to_cycles(SETUP_NS, SYS_CLK_NS),
                                           ns_to_cycles(SCK_LOW_NS, SYS_CLK_NS));
    localparam int unsigned HIGH_C = max_u(ns_to_cycles(SCK_HIGH_NS, SYS_CLK_NS),
                                           ns_to_cycles(HOLD_NS, SYS_CLK_NS));
    localparam int unsigned GAP_C  = ns_to_cycles(GAP_NS, SYS_CLK_NS);
    localparam int unsigned STB_C  = ns_to_cycles(STB_NS, SYS_CLK_NS);
    localparam int unsigned MAX_C  = max_u(max_u(LOW_C, HIGH_C), max_u(GAP_C, STB_C));
    localparam int unsigned CW     = $clog2(MAX_C + 1);

    logic          tmr_load, expire, sh_load, sh_shift, last_bit;
    logic [CW-1:0] tmr_val;
    seq_out_t      outs;

    serdrv_ctrl #(
        .CW(CW), .LOW_C(LOW_C), .HIGH_C(HIGH_C), .GAP_C(GAP_C), .STB_C(STB_C)
    ) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .expire(expire),
        .last_bit(last_bit), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .sh_load(sh_load), .sh_shift(sh_shift), .outs(outs)
    );

    serdrv_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(expire)
    );

    serdrv_shifter #(.W(W)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .load_word(in_data),
        .shift(sh_shift), .sdo(ser_data), .last_bit(last_bit)
    );

    assign in_ready   = outs.ready;
    assign ser_clk    = outs.sck;
    assign ser_strobe = outs.stb_pulse | bypass;
    assign ser_blank  = outs.shifting & bypass;
    assign done       = outs.done;
endmodule

// File: rtl/serdrv_load_seq_chk.sv
module serdrv_load_seq_chk (
    input logic clk,
    input logic rst,
    input logic bypass,
    input logic in_valid,
    input logic in_ready,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_strobe,
    input logic ser_blank,
    input logic done
);
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_data_before_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_data));

    assert_data_held_high_R5: assert property (@(posedge clk) disable iff (rst)
        ser_clk |=> (!ser_clk || $stable(ser_data)));

    assert_no_clk_in_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (ser_strobe && !bypass) |-> (!ser_clk && !in_ready));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    assert_blank_while_shift_R9: assert property (@(posedge clk) disable iff (rst)
        (bypass && ser_clk) |-> (ser_blank && ser_strobe));

    assert_no_blank_normal_R9: assert property (@(posedge clk) disable iff (rst)
        !bypass |-> !ser_blank);
endmodule

bind serdrv_load_seq serdrv_load_seq_chk u_chk (
    .clk(clk), .rst(rst), .bypass(bypass), .in_valid(in_valid),
    .in_ready(in_ready), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_strobe(ser_strobe), .ser_blank(ser_blank), .done(done)
);

// File: tb/serdrv_load_seq_test.sv
module serdrv_chain_mon #(
    parameter int W      = 10,
    parameter int NS     = 10,
    parameter int LOW_E  = 1,
    parameter int HIGH_E = 1,
    parameter int GAP_E  = 1,
    parameter int STB_E  = 1
) (
    input logic         clk,
    input logic         rst,
    input logic         bypass,
    input logic         sck,
    input logic         sdo,
    input logic         stb,
    input logic         blank,
    input logic         done,
    input logic [W-1:0] exp_word
);
    int checks = 0;
    int errs   = 0;
    logic [W-1:0] chain;
    int stable, hi_len, since_rise, stb_len, rises;
    logic p_sck, p_sdo, p_stb, p_byp, hold_val;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s (W=%0d): actual %0d expected %0d", req, W, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            chain = '0; stable = 0; hi_len = 0; since_rise = 0; stb_len = 0; rises = 0;
            p_sck = 0; p_sdo = 0; p_stb = 0; p_byp = 0; hold_val = 0;
        end else begin
            if (sdo == p_sdo) stable++; else stable = 1;
            since_rise++;
            if (sck && !p_sck) begin
                rises++;
                chain = {chain[W-2:0], sdo};
                hold_val = sdo;
                hi_len = 1;
                since_rise = 0;
                // R4: setup run before the rising edge
                chk((stable - 1) >= LOW_E && (stable - 1) * NS >= 25, "R4 setup", stable - 1, LOW_E);
                if (bypass) chk(blank == 1'b1, "R9 blank during shift", blank, 1);
            end else if (sck) begin
                hi_len++;
                if (sdo != hold_val) chk(0, "R5 data moved in high phase", sdo, hold_val);
            end
            if (!sck && p_sck)
                chk(hi_len == HIGH_E && hi_len * NS >= 50, "R5 high width", hi_len, HIGH_E);
            if (!bypass && !p_byp) begin
                if (stb && !p_stb) begin
                    chk(since_rise == HIGH_E + GAP_E && since_rise * NS >= 100,
                        "R6 clock to strobe", since_rise, HIGH_E + GAP_E);
                    stb_len = 1;
                end else if (stb) begin
                    stb_len++;
                end
                if (!stb && p_stb)
                    chk(stb_len == STB_E && stb_len * NS >= 50, "R7 strobe width", stb_len, STB_E);
                if (blank) chk(0, "R9 blank in normal mode", blank, 0);
            end
            if (bypass && !stb) chk(0, "R9 strobe held in bypass", stb, 1);
            if (done) begin
                chk(chain == exp_word, "R3 chain contents", chain, exp_word);
                chk(rises == W, "R3 rising edge count", rises, W);
                chk(blank == 1'b0, "R9 blank at done", blank, 0);
                rises = 0;
            end
            p_sck = sck; p_sdo = sdo; p_stb = stb; p_byp = bypass;
        end
    end
endmodule

module serdrv_load_seq_test;
    localparam int WA = 20, NSA = 10;
    localparam int WB = 10, NSB = 30;

    function automatic int cdiv(input int ns, input int p);
        int c;
        c = (ns + p - 1) / p;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic int low_c(input int p);  return mx(cdiv(25, p), cdiv(50, p)); endfunction
    function automatic int high_c(input int p); return mx(cdiv(50, p), cdiv(25, p)); endfunction
    function automatic int gap_c(input int p);  return cdiv(100, p); endfunction
    function automatic int stb_c(input int p);  return cdiv(50, p); endfunction
    function automatic int total_c(input int w, input int p);
        return w * (low_c(p) + high_c(p)) + gap_c(p) + stb_c(p);
    endfunction

    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic byp_a = 0, valid_a = 0, ready_a, sd_a, sc_a, st_a, bl_a, done_a;
    logic byp_b = 0, valid_b = 0, ready_b, sd_b, sc_b, st_b, bl_b, done_b;
    logic [WA-1:0] data_a = '0, exp_a = '0;
    logic [WB-1:0] data_b = '0, exp_b = '0;

    serdrv_load_seq #(.DEVICES(2), .SYS_CLK_NS(NSA)) uut (
        .clk(clk), .rst(rst), .bypass(byp_a), .in_valid(valid_a), .in_ready(ready_a),
        .in_data(data_a), .ser_data(sd_a), .ser_clk(sc_a), .ser_strobe(st_a),
        .ser_blank(bl_a), .done(done_a));

    serdrv_load_seq #(.DEVICES(1), .SYS_CLK_NS(NSB)) uut_b (
        .clk(clk), .rst(rst), .bypass(byp_b), .in_valid(valid_b), .in_ready(ready_b),
        .in_data(data_b), .ser_data(sd_b), .ser_clk(sc_b), .ser_strobe(st_b),
        .ser_blank(bl_b), .done(done_b));

    serdrv_chain_mon #(.W(WA), .NS(NSA), .LOW_E(low_c(NSA)), .HIGH_E(high_c(NSA)),
        .GAP_E(gap_c(NSA)), .STB_E(stb_c(NSA))) mon_a (
        .clk(clk), .rst(rst), .bypass(byp_a), .sck(sc_a), .sdo(sd_a), .stb(st_a),
        .blank(bl_a), .done(done_a), .exp_word(exp_a));

    serdrv_chain_mon #(.W(WB), .NS(NSB), .LOW_E(low_c(NSB)), .HIGH_E(high_c(NSB)),
        .GAP_E(gap_c(NSB)), .STB_E(stb_c(NSB))) mon_b (
        .clk(clk), .rst(rst), .bypass(byp_b), .sck(sc_b), .sdo(sd_b), .stb(st_b),
        .blank(bl_b), .done(done_b), .exp_word(exp_b));

    int checks = 0;
    int errs   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_in(input bit sel, input bit v, input logic [WA-1:0] w);
        if (sel) begin valid_b = v; data_b = w[WB-1:0]; end
        else     begin valid_a = v; data_a = w; end
    endtask

    // One transfer on instance sel; junk=1 offers other words while busy (R2)
    task automatic run(input bit sel, input logic [WA-1:0] word, input bit byp, input bit junk);
        int n;
        int t_exp;
        logic rdy, dn;
        @(negedge clk);
        if (sel) begin byp_b = byp; exp_b = word[WB-1:0]; t_exp = total_c(WB, NSB); end
        else     begin byp_a = byp; exp_a = word;         t_exp = total_c(WA, NSA); end
        set_in(sel, 1'b1, word);
        rdy = sel ? ready_b : ready_a;
        chk(rdy == 1'b1, "R2 ready before accept", rdy, 1);
        @(posedge clk);
        @(negedge clk);
        set_in(sel, 1'b0, ~word);
        rdy = sel ? ready_b : ready_a;
        chk(rdy == 1'b0, "R2 ready drops after accept", rdy, 0);
        n = 0;
        dn = 0;
        while (!dn && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (junk && n == 3)  set_in(sel, 1'b1, ~word);
            if (junk && n == 20) set_in(sel, 1'b0, ~word);
            dn  = sel ? done_b : done_a;
            rdy = sel ? ready_b : ready_a;
            if (rdy) chk(0, "R2 ready high while busy", n, 0);
        end
        chk(n == t_exp, "R8 cycles to done", n, t_exp);
        @(posedge clk);
        @(negedge clk);
        dn  = sel ? done_b : done_a;
        rdy = sel ? ready_b : ready_a;
        chk(dn == 1'b0, "R8 done one cycle", dn, 0);
        chk(rdy == 1'b1, "R8 ready returns", rdy, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle state after reset
        chk(ready_a && ready_b, "R1 ready after reset", {ready_a, ready_b}, 3);
        chk(!sc_a && !st_a && !bl_a && !done_a, "R1 outputs low (a)", {sc_a, st_a, bl_a, done_a}, 0);
        chk(!sc_b && !st_b && !bl_b && !done_b, "R1 outputs low (b)", {sc_b, st_b, bl_b, done_b}, 0);
        // R10: count derivation at two periods
        chk(total_c(WA, NSA) == 215, "R10 derived total a", total_c(WA, NSA), 215);
        chk(total_c(WB, NSB) == 46, "R10 derived total b", total_c(WB, NSB), 46);

        // Directed corners: R3 ordering with single MSB, zeros, ones, alternating
        run(0, 20'h80000, 0, 0);
        run(0, 20'h00000, 0, 0);
        run(0, 20'hFFFFF, 0, 0);
        run(0, 20'hAAAAA, 0, 1);
        run(1, 20'h00200, 0, 0);
        run(1, 20'h00155, 0, 1);
        // R9 bypass mode on both instances
        run(0, 20'h12345, 1, 0);
        run(1, 20'h003C1, 1, 0);
        // Random mix
        for (int i = 0; i < 12; i++) begin
            run(i[0], WA'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0);
        end
        @(negedge clk);
        byp_a = 0;
        byp_b = 0;
        repeat (2) @(negedge clk);
        chk(!st_a && !st_b, "R9 strobe low after bypass off", {st_a, st_b}, 0);

        checks += mon_a.checks + mon_b.checks;
        errs   += mon_a.errs + mon_b.errs;
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule